// File: doc/BRIEF.md
# Unaligned Byte/Halfword Access Splitter

This block sits between a core's 8-bit and 16-bit data port and a synchronous memory that is four bytes wide, has per-lane write strobes and returns read data one cycle after it samples the address. A request carries a 20-bit byte address, a size (byte or halfword), a direction and, for writes, the data. The block moves each byte onto the memory lane that its address selects and drives only the lanes that are used. For reads it takes the bytes from those lanes and builds a right-justified 16-bit result.

Most accesses fit inside one aligned four-byte word and need one memory cycle. The one exception is a halfword whose address ends in binary 11. Its two bytes then lie in two neighbouring words, so the block issues two memory cycles back to back and joins the two halves. A `ready` output shows that the block is idle and will take a request. A one-cycle `done` pulse marks the end of each access. On a read, `rdata` is valid from that pulse and holds its value until the next read completes.

Top module: `usplit_unit`

## Requirements
- R1: A byte access at offset k (address bits [1:0]) issues exactly one memory cycle at word address addr[19:2] with `mem_be` equal to 1<<k. A halfword at offset 0, 1 or 2 issues exactly one cycle with `mem_be` equal to 3<<k.
- R2: A halfword at offset 3 issues exactly two memory cycles on consecutive clocks. The first is at word addr[19:2] with `mem_be`=4'b1000. The second is at word addr[19:2]+1 with `mem_be`=4'b0001.
- R3: On a write, the low data byte (`req_wdata[7:0]`) goes to the lane of the address offset and the high byte (`req_wdata[15:8]`) goes to the next lane. For offset 3 the high byte goes to lane 0 of the following word. Lane i is `mem_wdata[8i+7:8i]`.
- R4: On a read, `rdata[7:0]` is the byte at the request address. `rdata[15:8]` is the byte at address+1 for a halfword and zero for a byte read. This includes the offset 3 case, where the two bytes come from two words.
- R5: Counting the clock cycle right after the accepting edge as cycle 1, `done` is high in cycle 2 + S + D. S is 1 for an offset 3 halfword and 0 otherwise. D is 1 for a read and 0 for a write.
- R6: `done` is high for exactly one cycle per access.
- R7: `ready` is high only when no access is in progress. A `req_valid` seen while `ready` is low is ignored and leaves memory unchanged.
- R8: After reset, `ready` is 1 and `mem_en` and `done` are 0.
- R9: The word address of the second cycle of a split access wraps from the top of the address space to word 0. For example, a halfword at 20'hFFFFF uses word 18'h3FFFF and then word 18'h00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = halfword, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data, low byte at the address |
| ready | output | 1 | Idle, will accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Assembled read result |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write (with `mem_en`) |
| mem_addr | output | 18 | Memory word address |
| mem_be | output | 4 | Per-lane write/lane-use strobes |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the address |

## Verification
On every cycle, the assertions check the following memory-side rules. Every memory cycle uses one or two lanes. Two memory cycles in a row occur only as a split pair, in which the top lane is followed by lane 0 at the next word, wrapping at the top of memory. The memory is never active while `ready` is high. `done` lasts one cycle and always follows memory activity. Only the bench's scenarios can show the rest: that bytes land in the right lanes, that read results are assembled and zero-padded correctly, that each access takes exactly the number of cycles it should, and that a request arriving while the block is busy is really ignored. The bench shows these by reading data back and counting cycles across every offset, size and direction.

// File: rtl/usplit_pkg.sv
package usplit_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BEAT0 = 2'd1,
      ST_BEAT1 = 2'd2,
      ST_RWAIT = 2'd3
   } usplit_state_t;
endpackage

// File: rtl/usplit_lane_map.sv
module usplit_lane_map #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int OFF_W  = 2
) (
   input  logic [OFF_W-1:0]        off,
   input  logic                    wide,
   input  logic                    beat,
   input  logic [LANE_W-1:0]       lo_b,
   input  logic [LANE_W-1:0]       hi_b,
   output logic [LANES-1:0]        be,
   output logic [LANES*LANE_W-1:0] wdata
);
   localparam logic [OFF_W-1:0] TOP_OFF = OFF_W'(LANES-1);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic lo_hit;
      logic hi_hit;
      always_comb begin
         lo_hit = !beat && (off == OFF_W'(i));
         if (i == 0)
            hi_hit = wide && beat;
         else
            hi_hit = wide && !beat && (off != TOP_OFF) &&
                     ((off + OFF_W'(1)) == OFF_W'(i));
      end
      assign be[i] = lo_hit | hi_hit;
      assign wdata[i*LANE_W +: LANE_W] = lo_hit ? lo_b :
                                         (hi_hit ? hi_b : '0);
   end
endmodule

// File: rtl/usplit_seq.sv
module usplit_seq
   import usplit_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   input  logic req_split,
   output logic ready,
   output logic accept,
   output logic to_beat1,
   output logic issue_end,
   output logic cap_first,
   output logic cap_last,
   output logic done,
   output logic split_q,
   output logic write_q
);
   usplit_state_t state, state_nx;

   assign ready     = (state == ST_IDLE);
   assign accept    = ready && req_valid;
   assign to_beat1  = (state == ST_BEAT0) && split_q;
   assign issue_end = ((state == ST_BEAT0) && !split_q) || (state == ST_BEAT1);
   assign cap_first = (state == ST_BEAT1) && !write_q;
   assign cap_last  = (state == ST_RWAIT);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (accept) state_nx = ST_BEAT0;
         ST_BEAT0: if (split_q) state_nx = ST_BEAT1;
                   else state_nx = write_q ? ST_IDLE : ST_RWAIT;
         ST_BEAT1: state_nx = write_q ? ST_IDLE : ST_RWAIT;
         ST_RWAIT: state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         split_q <= 1'b0;
         write_q <= 1'b0;
         done    <= 1'b0;
      end else begin
         state <= state_nx;
         done  <= (issue_end && write_q) || cap_last;
         if (accept) begin
            split_q <= req_split;
            write_q <= req_write;
         end
      end
   end
endmodule

// File: rtl/usplit_read_align.sv
module usplit_read_align #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int OFF_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap_first,
   input  logic                    cap_last,
   input  logic [OFF_W-1:0]        off,
   input  logic                    wide,
   input  logic                    split,
   input  logic [LANES*LANE_W-1:0] mem_rdata,
   output logic [2*LANE_W-1:0]     rdata
);
   logic [LANE_W-1:0] lane [LANES];
   logic [LANE_W-1:0] first_lo;

   for (genvar i = 0; i < LANES; i++) begin : g_unpack
      assign lane[i] = mem_rdata[i*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_lo <= '0;
         rdata    <= '0;
      end else begin
         if (cap_first)
            first_lo <= lane[LANES-1];
         if (cap_last) begin
            if (split)
               rdata <= {lane[0], first_lo};
            else
               rdata <= {(wide ? lane[off + OFF_W'(1)] : {LANE_W{1'b0}}), lane[off]};
         end
      end
   end
endmodule

// File: rtl/usplit_unit.sv
module usplit_unit #(
   parameter int ADDR_W = 20,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                req_valid,
   input  logic                                req_write,
   input  logic                                req_wide,
   input  logic [ADDR_W-1:0]                   req_addr,
   input  logic [2*LANE_W-1:0]                 req_wdata,
   output logic                                ready,
   output logic                                done,
   output logic [2*LANE_W-1:0]                 rdata,
   output logic                                mem_en,
   output logic                                mem_we,
   output logic [ADDR_W-$clog2(LANES)-1:0]     mem_addr,
   output logic [LANES-1:0]                    mem_be,
   output logic [LANES*LANE_W-1:0]             mem_wdata,
   input  logic [LANES*LANE_W-1:0]             mem_rdata
);
   localparam int OFF_W  = $clog2(LANES);
   localparam int WA_W   = ADDR_W - OFF_W;
   localparam int DATA_W = LANES * LANE_W;

   if (LANES < 2 || (1 << OFF_W) != LANES) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("LANE_W must be positive");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed the lane offset width");
   end

   logic             accept, to_beat1, issue_end, cap_first, cap_last;
   logic             split_q, write_q;
   logic             req_split;
   logic [OFF_W-1:0] req_off;
   logic [OFF_W-1:0] h_off;
   logic             h_wide;
   logic [WA_W-1:0]  h_waddr;
   logic [LANE_W-1:0] h_lo, h_hi;
   logic [LANES-1:0]  be0, be1;
   logic [DATA_W-1:0] wd0, wd1;

   assign req_off   = req_addr[OFF_W-1:0];
   assign req_split = req_wide && (req_off == {OFF_W{1'b1}});

   usplit_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_split (req_split),
      .ready     (ready),
      .accept    (accept),
      .to_beat1  (to_beat1),
      .issue_end (issue_end),
      .cap_first (cap_first),
      .cap_last  (cap_last),
      .done      (done),
      .split_q   (split_q),
      .write_q   (write_q)
   );

   usplit_lane_map #(.LANES(LANES), .LANE_W(LANE_W), .OFF_W(OFF_W)) u_map0 (
      .off   (req_off),
      .wide  (req_wide),
      .beat  (1'b0),
      .lo_b  (req_wdata[LANE_W-1:0]),
      .hi_b  (req_wdata[2*LANE_W-1:LANE_W]),
      .be    (be0),
      .wdata (wd0)
   );

   usplit_lane_map #(.LANES(LANES), .LANE_W(LANE_W), .OFF_W(OFF_W)) u_map1 (
      .off   (h_off),
      .wide  (h_wide),
      .beat  (1'b1),
      .lo_b  (h_lo),
      .hi_b  (h_hi),
      .be    (be1),
      .wdata (wd1)
   );

   usplit_read_align #(.LANES(LANES), .LANE_W(LANE_W), .OFF_W(OFF_W)) u_ralign (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_first (cap_first),
      .cap_last  (cap_last),
      .off       (h_off),
      .wide      (h_wide),
      .split     (split_q),
      .mem_rdata (mem_rdata),
      .rdata     (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_off   <= '0;
         h_wide  <= 1'b0;
         h_waddr <= '0;
         h_lo    <= '0;
         h_hi    <= '0;
      end else if (accept) begin
         h_off   <= req_off;
         h_wide  <= req_wide;
         h_waddr <= req_addr[ADDR_W-1:OFF_W];
         h_lo    <= req_wdata[LANE_W-1:0];
         h_hi    <= req_wdata[2*LANE_W-1:LANE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_en    <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_be    <= '0;
         mem_wdata <= '0;
      end else if (accept) begin
         mem_en    <= 1'b1;
         mem_we    <= req_write;
         mem_addr  <= req_addr[ADDR_W-1:OFF_W];
         mem_be    <= be0;
         mem_wdata <= wd0;
      end else if (to_beat1) begin
         mem_addr  <= h_waddr + WA_W'(1);
         mem_be    <= be1;
         mem_wdata <= wd1;
      end else if (issue_end) begin
         mem_en    <= 1'b0;
         mem_we    <= 1'b0;
         mem_be    <= '0;
         mem_wdata <= '0;
      end
   end
endmodule

// File: rtl/usplit_chk.sv
module usplit_chk #(
   parameter int ADDR_W = 20,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            req_valid,
   input logic                            ready,
   input logic                            done,
   input logic                            mem_en,
   input logic [ADDR_W-$clog2(LANES)-1:0] mem_addr,
   input logic [LANES-1:0]                mem_be
);
   localparam int WA_W = ADDR_W - $clog2(LANES);
   localparam logic [LANES-1:0] TOP_LANE = LANES'(1) << (LANES-1);

   // R1
   lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> ($countones(mem_be) >= 1 && $countones(mem_be) <= 2));

   // R2
   split_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && $past(mem_en)) |-> (mem_be == LANES'(1) && $past(mem_be) == TOP_LANE));

   // R9
   split_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && $past(mem_en)) |-> (mem_addr == WA_W'($past(mem_addr) + 1'b1)));

   // R7
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> !ready);

   // R7
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req_valid) |=> (!ready && mem_en));

   // R6
   pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(mem_en) || $past(mem_en, 2)));
endmodule

bind usplit_unit usplit_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .ready     (ready),
   .done      (done),
   .mem_en    (mem_en),
   .mem_addr  (mem_addr),
   .mem_be    (mem_be)
);

// File: tb/usplit_unit_tb.sv
module usplit_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        ready, done;
   logic [15:0] rdata;
   logic        mem_en, mem_we;
   logic [17:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;

   int checks = 0;
   int fails  = 0;

   logic [31:0] bmem [16];
   logic [7:0]  refm [64];

   always #10 clk = ~clk;

   usplit_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
      .ready(ready), .done(done), .rdata(rdata), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            for (int l = 0; l < 4; l++)
               if (mem_be[l]) bmem[mem_addr[3:0]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
         end else begin
            mem_rdata <= bmem[mem_addr[3:0]];
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input bit w, input bit wide, input logic [19:0] a,
                         input logic [15:0] wd, input bit intrude);
      int          n;
      int          beats;
      logic [3:0]  bes [4];
      logic [17:0] adr [4];
      bit          split;
      logic [3:0]  exp_be;
      logic [15:0] exp_rd;
      logic [19:0] a1;
      split = wide && (a[1:0] == 2'b11);
      a1 = a + 20'd1;
      @(negedge clk);
      while (!ready) @(negedge clk);
      req_valid = 1'b1; req_write = w; req_wide = wide; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = intrude;
      if (intrude) begin
         req_write = 1'b1; req_wide = 1'b1; req_addr = a ^ 20'h00020; req_wdata = 16'hDEAD;
      end
      n = 1; beats = 0;
      forever begin
         if (mem_en && beats < 4) begin
            bes[beats] = mem_be; adr[beats] = mem_addr; beats++;
         end
         if (done || n > 12) break;
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      // R5 latency
      check(n == 2 + int'(split) + int'(!w), "R5 latency", n, 2 + int'(split) + int'(!w));
      if (split) begin
         // R2 two beats, lanes 1000 then 0001
         check(beats == 2, "R2 beat count", beats, 2);
         check(bes[0] == 4'b1000 && bes[1] == 4'b0001, "R2 byte enables",
               {bes[0], bes[1]}, 8'h81);
         // R9 second word follows first, wrapping at the top
         check(adr[0] == a[19:2] && adr[1] == a[19:2] + 18'd1, "R9 split word address",
               {adr[0], adr[1]}, {a[19:2], 18'(a[19:2] + 18'd1)});
      end else begin
         exp_be = (wide ? 4'b0011 : 4'b0001) << a[1:0];
         check(beats == 1, "R1 beat count", beats, 1);
         check(bes[0] == exp_be && adr[0] == a[19:2], "R1 enables/address",
               {bes[0], adr[0]}, {exp_be, a[19:2]});
      end
      if (w) begin
         refm[a[5:0]] = wd[7:0];
         if (wide) refm[a1[5:0]] = wd[15:8];
      end else begin
         exp_rd = wide ? {refm[a1[5:0]], refm[a[5:0]]} : {8'h00, refm[a[5:0]]};
         check(rdata == exp_rd, "R4 read assembly", rdata, exp_rd);
      end
   endtask

   task automatic write_then_read(input bit wide, input logic [19:0] a, input logic [15:0] wd);
      access(1'b0, wide, a, 16'h0, 1'b0);   // R4 read of existing contents
      access(1'b1, wide, a, wd, 1'b0);      // R3 write lane placement
      access(1'b0, wide, a, 16'h0, 1'b0);   // R3 readback through R4
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [19:0] bases [3];
      logic [19:0] a;
      bases[0] = 20'h00010; bases[1] = 20'h00024; bases[2] = 20'hFFFF8;
      for (int i = 0; i < 64; i++) refm[i] = 8'(i * 7 + 3);
      for (int wi = 0; wi < 16; wi++)
         bmem[wi] = {refm[wi*4+3], refm[wi*4+2], refm[wi*4+1], refm[wi*4]};
      repeat (3) @(negedge clk);
      // R8 reset state
      check(ready == 1'b1 && mem_en == 1'b0 && done == 1'b0, "R8 reset state",
            {ready, mem_en, done}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready == 1'b1 && mem_en == 1'b0 && done == 1'b0, "R8 after reset release",
            {ready, mem_en, done}, 3'b100);
      for (int b = 0; b < 3; b++)
         for (int off = 0; off < 4; off++)
            for (int wide = 0; wide < 2; wide++) begin
               a = bases[b] + 20'(off);
               write_then_read(wide[0], a,
                               {8'(a * 3 + 20'(wide) + 20'h5A), 8'(a + 20'(off * 17) + 20'h11)});
            end
      // R9 wrap from top of address space to word 0
      write_then_read(1'b1, 20'hFFFFF, 16'hC3A5);
      write_then_read(1'b1, 20'h00003, 16'h1E2D);
      // R7 request while busy is ignored: intruder targets a ^ 0x20
      access(1'b1, 1'b1, 20'h00005, 16'h7788, 1'b1);
      access(1'b0, 1'b1, 20'h00025, 16'h0, 1'b0);    // R7 intruder location unchanged
      access(1'b1, 1'b0, 20'h0000B, 16'h0099, 1'b1);
      access(1'b0, 1'b1, 20'h0002B, 16'h0, 1'b0);    // R7
      access(1'b0, 1'b1, 20'h00005, 16'h0, 1'b0);
      // R6 done single pulse and ready while idle
      @(negedge clk);
      check(done == 1'b0 && ready == 1'b1, "R6 done cleared when idle", {done, ready}, 2'b01);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule